// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block chooses which of a set of interrupt lines should be serviced next and whether it may interrupt the handler that is already running. Each line carries a pending flag and an enable flag, and it has an 8-bit priority setting that is written through a small configuration port. Only the upper four bits of each setting are stored. A 3-bit grouping value, also written through the configuration port, divides those four bits into a preemption level (upper part) and a sub-level (lower part).

Every clock, the candidates are the lines that are both pending and enabled. The winner is the candidate with the lowest preemption level. A tie on that level goes to the lower sub-level, and a remaining tie goes to the lower line number. The winner's preemption level is then compared against the level of the active handler, which arrives on an input. The block raises a preempt request only when the winner is strictly more urgent than that level. All results are registered.

The block contains no state machine. Its sequential state is made of three parts: the priority storage, the grouping register and one output register stage.

Top module: `ipr_resolver`

## Requirements
- R1: A write to `cfg_prio` stores only bits [7:4] of the value for line `cfg_line`. `rd_prio` then returns those four bits in [7:4] and zeros in [3:0]. After reset every line reads 0.
- R2: A line takes part in arbitration only when both its pending bit and its enable bit are 1. With no such line, `win_vld` and `win_preempt` are 0.
- R3: Among the candidates, the line whose preemption level is numerically smallest wins.
- R4: When candidates share the smallest preemption level, the one with the smallest sub-level wins.
- R5: When candidates share both levels, the lowest line number wins.
- R6: The grouping value selects how many of the 4 stored bits form the preemption level: values 0 to 3 select 0, and values 4, 5, 6 and 7 select 1, 2, 3 and 4. The remaining low bits form the sub-level. `win_pre` and `win_sub` carry both levels right-aligned.
- R7: `win_preempt` is 1 when a winner exists and its preemption level is strictly less than `act_lvl`. The value 16 on `act_lvl` means that no handler is active.
- R8: A winner whose preemption level equals or exceeds `act_lvl` never raises `win_preempt`, even if its sub-level is smaller.
- R9: All winner outputs are registered. They reflect the pending, enable and active-level inputs present before a clock edge, and the stored settings from before that edge. Reset clears the outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Priority write strobe |
| cfg_line | input | IDX_W | Line whose priority is written |
| cfg_prio | input | 8 | Priority write value (upper 4 bits kept) |
| grp_we | input | 1 | Grouping write strobe |
| grp_val | input | 3 | Grouping value |
| rd_line | input | IDX_W | Line whose priority is read back |
| rd_prio | output | 8 | Stored priority of `rd_line`, low 4 bits zero |
| pend | input | N_LINES | Pending flag per line |
| enab | input | N_LINES | Enable flag per line |
| act_lvl | input | 5 | Preemption level of running handler, 16 = none |
| win_vld | output | 1 | A winner exists |
| win_idx | output | IDX_W | Winning line number |
| win_pre | output | 4 | Winner's preemption level |
| win_sub | output | 4 | Winner's sub-level |
| win_preempt | output | 1 | Winner may interrupt the running handler |

## Verification
The five winner outputs fall due one clock edge after the inputs that produced them. A priority or grouping write changes the stored state at an edge, so its effect appears on the winner outputs one edge later. It appears on `rd_prio` as soon as that edge has passed. The bench drives all inputs at the falling edge and computes the expected result from its own model before the rising edge. It updates the model's stored settings only after that edge and compares at the next falling edge. This reproduces the single register stage exactly. Winner index and levels are compared only while `win_vld` is expected high.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    localparam int IPR_REG_W  = 8;
    localparam int IPR_IMPL_W = 4;
    localparam int IPR_GRP_W  = 3;
    localparam int IPR_PB_W   = 3;

    // Number of stored bits assigned to the preemption level (R6)
    function automatic logic [IPR_PB_W-1:0] grp_to_pre_bits(input logic [IPR_GRP_W-1:0] g);
        logic [IPR_PB_W-1:0] r;
        if (g < 3'd4) r = '0;
        else          r = IPR_PB_W'(g - 3'd3);
        return r;
    endfunction

endpackage

// File: rtl/ipr_prio_store.sv
module ipr_prio_store
    import ipr_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int REG_W   = IPR_REG_W,
    parameter int IMPL_W  = IPR_IMPL_W,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_line,
    input  logic [REG_W-1:0]          cfg_prio,
    input  logic                      grp_we,
    input  logic [IPR_GRP_W-1:0]      grp_val,
    input  logic [IDX_W-1:0]          rd_line,
    output logic [REG_W-1:0]          rd_prio,
    output logic [N_LINES*IMPL_W-1:0] prio_flat,
    output logic [IPR_PB_W-1:0]       pre_bits
);

    localparam int LOW_W = REG_W - IMPL_W;

    logic [IMPL_W-1:0]    prio_q [N_LINES];
    logic [IPR_GRP_W-1:0] grp_q;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                prio_q[g] <= '0;
            else if (cfg_we && (cfg_line == IDX_W'(g)))
                prio_q[g] <= cfg_prio[REG_W-1 -: IMPL_W];
        end
        assign prio_flat[g*IMPL_W +: IMPL_W] = prio_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      grp_q <= '0;
        else if (grp_we) grp_q <= grp_val;
    end

    assign pre_bits = grp_to_pre_bits(grp_q);

    always_comb begin
        if (int'(rd_line) < N_LINES)
            rd_prio = {prio_q[rd_line], {LOW_W{1'b0}}};
        else
            rd_prio = '0;
    end

endmodule

// File: rtl/ipr_level_split.sv
module ipr_level_split
    import ipr_pkg::*;
#(
    parameter int IMPL_W = IPR_IMPL_W
) (
    input  logic [IMPL_W-1:0]   prio,
    input  logic [IPR_PB_W-1:0] pre_bits,
    output logic [IMPL_W-1:0]   lvl_pre,
    output logic [IMPL_W-1:0]   lvl_sub
);

    localparam logic [IPR_PB_W-1:0] FULL = IPR_PB_W'(IMPL_W);
    localparam logic [IMPL_W-1:0]   ONES = '1;

    always_comb begin
        lvl_pre = prio >> (FULL - pre_bits);
        lvl_sub = prio & (ONES >> pre_bits);
    end

endmodule

// File: rtl/ipr_select.sv
module ipr_select
    import ipr_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IMPL_W  = IPR_IMPL_W,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic [N_LINES-1:0]        cand,
    input  logic [N_LINES*IMPL_W-1:0] pre_flat,
    input  logic [N_LINES*IMPL_W-1:0] sub_flat,
    output logic                      sel_vld,
    output logic [IDX_W-1:0]          sel_idx,
    output logic [IMPL_W-1:0]         sel_pre,
    output logic [IMPL_W-1:0]         sel_sub
);

    logic              c_vld [N_LINES+1];
    logic [IDX_W-1:0]  c_idx [N_LINES+1];
    logic [IMPL_W-1:0] c_pre [N_LINES+1];
    logic [IMPL_W-1:0] c_sub [N_LINES+1];

    assign c_vld[0] = 1'b0;
    assign c_idx[0] = '0;
    assign c_pre[0] = '0;
    assign c_sub[0] = '0;

    // Lines are visited upward; only a strictly better key replaces the
    // holder, so an equal key keeps the lower line number.
    for (genvar g = 0; g < N_LINES; g++) begin : g_stage
        logic [IMPL_W-1:0] my_pre;
        logic [IMPL_W-1:0] my_sub;
        logic              better;

        assign my_pre = pre_flat[g*IMPL_W +: IMPL_W];
        assign my_sub = sub_flat[g*IMPL_W +: IMPL_W];

        always_comb begin
            better = 1'b0;
            if (cand[g]) begin
                if (!c_vld[g])                  better = 1'b1;
                else if (my_pre < c_pre[g])     better = 1'b1;
                else if (my_pre == c_pre[g] && my_sub < c_sub[g])
                                                better = 1'b1;
            end
        end

        assign c_vld[g+1] = c_vld[g] | cand[g];
        assign c_idx[g+1] = better ? IDX_W'(g) : c_idx[g];
        assign c_pre[g+1] = better ? my_pre    : c_pre[g];
        assign c_sub[g+1] = better ? my_sub    : c_sub[g];
    end

    assign sel_vld = c_vld[N_LINES];
    assign sel_idx = c_idx[N_LINES];
    assign sel_pre = c_pre[N_LINES];
    assign sel_sub = c_sub[N_LINES];

endmodule

// File: rtl/ipr_resolver.sv
module ipr_resolver
    import ipr_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [IDX_W-1:0]        cfg_line,
    input  logic [IPR_REG_W-1:0]    cfg_prio,
    input  logic                    grp_we,
    input  logic [IPR_GRP_W-1:0]    grp_val,
    input  logic [IDX_W-1:0]        rd_line,
    output logic [IPR_REG_W-1:0]    rd_prio,
    input  logic [N_LINES-1:0]      pend,
    input  logic [N_LINES-1:0]      enab,
    input  logic [IPR_IMPL_W:0]     act_lvl,
    output logic                    win_vld,
    output logic [IDX_W-1:0]        win_idx,
    output logic [IPR_IMPL_W-1:0]   win_pre,
    output logic [IPR_IMPL_W-1:0]   win_sub,
    output logic                    win_preempt
);

    localparam int IMPL_W = IPR_IMPL_W;

    logic [N_LINES*IMPL_W-1:0] prio_flat;
    logic [N_LINES*IMPL_W-1:0] pre_flat;
    logic [N_LINES*IMPL_W-1:0] sub_flat;
    logic [IPR_PB_W-1:0]       pre_bits;
    logic [N_LINES-1:0]        cand;

    logic              sel_vld;
    logic [IDX_W-1:0]  sel_idx;
    logic [IMPL_W-1:0] sel_pre;
    logic [IMPL_W-1:0] sel_sub;

    logic              nxt_vld;
    logic [IDX_W-1:0]  nxt_idx;
    logic [IMPL_W-1:0] nxt_pre;
    logic [IMPL_W-1:0] nxt_sub;
    logic              nxt_preempt;

    ipr_prio_store #(
        .N_LINES (N_LINES),
        .REG_W   (IPR_REG_W),
        .IMPL_W  (IMPL_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_line  (cfg_line),
        .cfg_prio  (cfg_prio),
        .grp_we    (grp_we),
        .grp_val   (grp_val),
        .rd_line   (rd_line),
        .rd_prio   (rd_prio),
        .prio_flat (prio_flat),
        .pre_bits  (pre_bits)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_split
        ipr_level_split #(.IMPL_W(IMPL_W)) u_split (
            .prio     (prio_flat[g*IMPL_W +: IMPL_W]),
            .pre_bits (pre_bits),
            .lvl_pre  (pre_flat[g*IMPL_W +: IMPL_W]),
            .lvl_sub  (sub_flat[g*IMPL_W +: IMPL_W])
        );
    end

    assign cand = pend & enab;

    ipr_select #(
        .N_LINES (N_LINES),
        .IMPL_W  (IMPL_W),
        .IDX_W   (IDX_W)
    ) u_select (
        .cand     (cand),
        .pre_flat (pre_flat),
        .sub_flat (sub_flat),
        .sel_vld  (sel_vld),
        .sel_idx  (sel_idx),
        .sel_pre  (sel_pre),
        .sel_sub  (sel_sub)
    );

    always_comb begin
        nxt_vld     = sel_vld;
        nxt_idx     = sel_idx;
        nxt_pre     = sel_pre;
        nxt_sub     = sel_sub;
        nxt_preempt = sel_vld && ({1'b0, sel_pre} < act_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_vld     <= 1'b0;
            win_idx     <= '0;
            win_pre     <= '0;
            win_sub     <= '0;
            win_preempt <= 1'b0;
        end else begin
            win_vld     <= nxt_vld;
            win_idx     <= nxt_idx;
            win_pre     <= nxt_pre;
            win_sub     <= nxt_sub;
            win_preempt <= nxt_preempt;
        end
    end

endmodule

// File: rtl/ipr_resolver_chk.sv
module ipr_resolver_chk
    import ipr_pkg::*;
#(
    parameter int N_LINES = 8,
    parameter int IDX_W   = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_LINES-1:0]    pend,
    input logic [N_LINES-1:0]    enab,
    input logic [IPR_IMPL_W:0]   act_lvl,
    input logic [IPR_REG_W-1:0]  rd_prio,
    input logic                  win_vld,
    input logic [IDX_W-1:0]      win_idx,
    input logic [IPR_IMPL_W-1:0] win_pre,
    input logic                  win_preempt
);

    localparam int LOW_W = IPR_REG_W - IPR_IMPL_W;

    p_no_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & enab) == '0) |=> (!win_vld && !win_preempt));

    p_has_cand_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & enab) != '0) |=> win_vld);

    p_win_is_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & enab) != '0) |=>
            (($past(pend & enab) & (N_LINES'(1) << win_idx)) != '0));

    p_idle_preempts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((pend & enab) != '0) && (act_lvl == 5'd16)) |=> win_preempt);

    p_strict_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        win_preempt |-> (win_vld && ({1'b0, win_pre} < $past(act_lvl))));

    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_prio[LOW_W-1:0] == '0);

endmodule

bind ipr_resolver ipr_resolver_chk #(
    .N_LINES (N_LINES),
    .IDX_W   (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend        (pend),
    .enab        (enab),
    .act_lvl     (act_lvl),
    .rd_prio     (rd_prio),
    .win_vld     (win_vld),
    .win_idx     (win_idx),
    .win_pre     (win_pre),
    .win_preempt (win_preempt)
);

// File: tb/tb_ipr_resolver.sv
`timescale 1ns/1ps
module tb_ipr_resolver;

    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [IW-1:0] cfg_line;
    logic [7:0]    cfg_prio;
    logic          grp_we;
    logic [2:0]    grp_val;
    logic [IW-1:0] rd_line;
    logic [7:0]    rd_prio;
    logic [N-1:0]  pend;
    logic [N-1:0]  enab;
    logic [4:0]    act_lvl;
    logic          win_vld;
    logic [IW-1:0] win_idx;
    logic [3:0]    win_pre;
    logic [3:0]    win_sub;
    logic          win_preempt;

    always #2.5 clk = ~clk;

    ipr_resolver #(.N_LINES(N)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_line(cfg_line), .cfg_prio(cfg_prio),
        .grp_we(grp_we), .grp_val(grp_val),
        .rd_line(rd_line), .rd_prio(rd_prio),
        .pend(pend), .enab(enab), .act_lvl(act_lvl),
        .win_vld(win_vld), .win_idx(win_idx), .win_pre(win_pre),
        .win_sub(win_sub), .win_preempt(win_preempt)
    );

    int mprio[N];
    int mgrp;
    int n_cmp = 0;
    int n_bad = 0;
    int e_vld, e_idx, e_pre, e_sub, e_pmt;

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: three explicit tiers over the candidate lines
    task automatic model();
        int pb;
        pb = (mgrp < 4) ? 0 : mgrp - 3;
        e_vld = 0; e_idx = 0; e_pre = 0; e_sub = 0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && enab[i]) begin
                int pr, sb;
                pr = mprio[i] >> (4 - pb);
                sb = mprio[i] % (1 << (4 - pb));
                if (e_vld == 0 || pr < e_pre ||
                    (pr == e_pre && sb < e_sub) ||
                    (pr == e_pre && sb == e_sub && i < e_idx)) begin
                    e_vld = 1; e_idx = i; e_pre = pr; e_sub = sb;
                end
            end
        end
        e_pmt = (e_vld != 0 && e_pre < int'(act_lvl)) ? 1 : 0;
    endtask

    task automatic step(input string tag);
        model();
        @(posedge clk);
        if (cfg_we) mprio[cfg_line] = int'(cfg_prio[7:4]);
        if (grp_we) mgrp = int'(grp_val);
        @(negedge clk);
        check(tag, "win_vld", int'(win_vld), e_vld);
        check(tag, "win_preempt", int'(win_preempt), e_pmt);
        if (e_vld != 0) begin
            check(tag, "win_idx", int'(win_idx), e_idx);
            check(tag, "win_pre", int'(win_pre), e_pre);
            check(tag, "win_sub", int'(win_sub), e_sub);
        end
        check("R1", "rd_prio", int'(rd_prio), mprio[rd_line] * 16);
        cfg_we = 1'b0;
        grp_we = 1'b0;
    endtask

    task automatic wr_prio(input int line, input int val);
        cfg_we = 1'b1; cfg_line = IW'(line); cfg_prio = 8'(val); rd_line = IW'(line);
        step("R1");
    endtask

    task automatic wr_grp(input int g);
        grp_we = 1'b1; grp_val = 3'(g);
        step("R6");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mprio[i] = 0;
        mgrp = 0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_line = '0; cfg_prio = '0;
        grp_we = 1'b0; grp_val = '0; rd_line = '0;
        pend = '0; enab = '0; act_lvl = 5'd16;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        check("R9", "reset win_vld", int'(win_vld), 0);
        check("R9", "reset win_preempt", int'(win_preempt), 0);
        check("R9", "reset rd_prio", int'(rd_prio), 0);

        // R1: low bits dropped
        wr_prio(2, 'hA7);
        wr_prio(0, 'h5C);
        wr_prio(1, 'h3F);
        wr_prio(3, 'h30);
        wr_prio(4, 'h11);
        wr_prio(5, 'hF0);
        wr_prio(6, 'h70);
        wr_prio(7, 'h92);

        wr_grp(5);  // R6: 2 preemption bits

        // R2: pending but disabled lines are ignored
        pend = '1; enab = '0; act_lvl = 5'd16;
        step("R2");
        pend = '0; enab = '1;
        step("R2");

        // R4: equal preemption level, lower sub-level wins (line 4 over 1 and 3)
        pend = 8'h1A; enab = '1; act_lvl = 5'd16;
        step("R4");
        step("R7");

        // R5: equal levels, lowest line number wins
        pend = 8'h0A; act_lvl = 5'd0;
        step("R5");
        step("R8");   // level 0 not strictly below 0

        // R3 with R7/R8: grouping 7 gives 4 preemption bits
        wr_grp(7);
        pend = 8'h05; act_lvl = 5'd6;
        step("R3");
        act_lvl = 5'd5;
        step("R8");
        act_lvl = 5'd16;
        step("R7");

        // R6: sweep all grouping values with two candidates
        pend = 8'h06;
        for (int g = 0; g < 8; g++) begin
            wr_grp(g);
            act_lvl = 5'd1;
            step("R6");
        end

        // R9: output follows one edge after pend change
        pend = 8'h80; act_lvl = 5'd16;
        step("R9");
        pend = 8'h00;
        step("R9");

        // R3: mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            pend    = N'($urandom);
            enab    = N'($urandom);
            act_lvl = 5'($urandom_range(0, 16));
            rd_line = IW'($urandom);
            if ($urandom_range(0, 7) == 0) begin
                cfg_we = 1'b1; cfg_line = IW'($urandom); cfg_prio = 8'($urandom);
            end
            if ($urandom_range(0, 15) == 0) begin
                grp_we = 1'b1; grp_val = 3'($urandom);
            end
            step("R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule